// File: doc/BRIEF.md
# Edge-Triggered Interrupt and Event Line Controller

The block watches a vector of input lines that are already synchronous to its clock. It reports the selected transitions on each line. Each line has its own trigger choice: rising, falling, both or neither. A detected transition can do either or both of two things. It can latch into a sticky pending bit that drives a level interrupt output. It can also produce a one-cycle event pulse. Each path has its own per-line enable mask.

Software reaches the block through a simple register port: one write strobe with a select code and data, and a separate combinational read select. The pending register is cleared by writing ones. A software-trigger register acts like a hardware transition on any line where a one is written, whatever that line's trigger choice. The intended users are an interrupt controller, which takes the interrupt vector, and wake or sequencing logic, which takes the event pulses.

Top module: `edge_irq_evt_ctrl`

## Requirements
- R1: After reset all registers read as zero, and `irq_out` and `evt_out` are zero.
- R2: The register select codes are: 0 = rising enable, 1 = falling enable, 2 = interrupt mask, 3 = event mask, 4 = pending (write 1 to clear), 5 = software trigger. Bit i of each register belongs to line i. Codes 6 and 7 ignore writes and read as zero. The software-trigger register always reads as zero.
- R3: A 0-to-1 change on a line whose rising enable is set is detected at the first clock edge that sees the new value. A line whose rising enable is clear ignores rising changes.
- R4: A 1-to-0 change on a line whose falling enable is set is detected in the same way. With both enables set, both directions are detected.
- R5: A detection raises that line's `evt_out` bit for exactly one cycle, in the cycle after the clock edge that detected it, if the line's event mask bit is set. The interrupt mask has no effect on this pulse.
- R6: A detection sets the line's pending bit at the next clock edge only if the line's interrupt mask bit is set. The pending bit then holds. `irq_out` equals pending AND interrupt mask.
- R7: Writing pending with a 1 in bit i clears pending bit i. A 0 in bit i leaves that bit unchanged.
- R8: If a clear of a pending bit and a new detection for that line (with the interrupt mask set) reach the same clock edge, the pending bit stays set.
- R9: Writing 1 to bit i of the software-trigger register acts as a detection on line i, with the same timing as R3, even when both edge enables of that line are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_in | input | NUM_LINES | Monitored lines, already synchronous to clk |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select code for writes |
| wr_data | input | NUM_LINES | Write data |
| rd_sel | input | 3 | Register select code for reads |
| rd_data | output | NUM_LINES | Read data for rd_sel |
| irq_out | output | NUM_LINES | Per-line interrupt level |
| evt_out | output | NUM_LINES | Per-line single-cycle event pulse |

## Verification
The hardest case to reach is a pending clear and a fresh detection meeting at the same clock edge on the same line. The line must already be pending, then transition again, and the write-one-to-clear must be timed to arrive exactly one cycle after that transition. The bench builds this step by step. It first sets pending with a rising transition. At a falling clock edge it drops the line, with falling detection enabled, then issues the clear at the very next falling edge. It also sweeps every line through all sixteen combinations of the two edge enables and the two masks, on both transition directions.

// File: rtl/eic_pkg.sv
package eic_pkg;
  localparam int SEL_W = 3;
  typedef enum logic [SEL_W-1:0] {
    SEL_RISE = 3'd0,
    SEL_FALL = 3'd1,
    SEL_IMSK = 3'd2,
    SEL_EMSK = 3'd3,
    SEL_PEND = 3'd4,
    SEL_SWT  = 3'd5
  } sel_e;
endpackage

// File: rtl/eic_cfg_regs.sv
module eic_cfg_regs
  import eic_pkg::*;
#(
  parameter int NUM_LINES = 24
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [SEL_W-1:0]     wr_sel,
  input  logic [NUM_LINES-1:0] wr_data,
  output logic [NUM_LINES-1:0] rise_en,
  output logic [NUM_LINES-1:0] fall_en,
  output logic [NUM_LINES-1:0] irq_msk,
  output logic [NUM_LINES-1:0] evt_msk,
  output logic [NUM_LINES-1:0] sw_hit,
  output logic [NUM_LINES-1:0] pend_clr
);
  function automatic logic [NUM_LINES-1:0] strobe_for(
    input logic en, input logic [SEL_W-1:0] sel, input sel_e want,
    input logic [NUM_LINES-1:0] d);
    return (en && sel == want) ? d : '0;
  endfunction

  assign sw_hit   = strobe_for(wr_en, wr_sel, SEL_SWT,  wr_data);
  assign pend_clr = strobe_for(wr_en, wr_sel, SEL_PEND, wr_data);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rise_en <= '0;
      fall_en <= '0;
      irq_msk <= '0;
      evt_msk <= '0;
    end else if (wr_en) begin
      case (wr_sel)
        SEL_RISE: rise_en <= wr_data;
        SEL_FALL: fall_en <= wr_data;
        SEL_IMSK: irq_msk <= wr_data;
        SEL_EMSK: evt_msk <= wr_data;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/eic_edge_det.sv
module eic_edge_det #(
  parameter int NUM_LINES = 24
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] line_in,
  input  logic [NUM_LINES-1:0] rise_en,
  input  logic [NUM_LINES-1:0] fall_en,
  input  logic [NUM_LINES-1:0] sw_hit,
  output logic [NUM_LINES-1:0] raw_hit,
  output logic [NUM_LINES-1:0] det_q
);
  logic [NUM_LINES-1:0] prev_q;

  function automatic logic [NUM_LINES-1:0] edge_select(
    input logic [NUM_LINES-1:0] now, input logic [NUM_LINES-1:0] was,
    input logic [NUM_LINES-1:0] ren, input logic [NUM_LINES-1:0] fen);
    return (now & ~was & ren) | (~now & was & fen);
  endfunction

  assign raw_hit = edge_select(line_in, prev_q, rise_en, fall_en) | sw_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= '0;
      det_q  <= '0;
    end else begin
      prev_q <= line_in;
      det_q  <= raw_hit;
    end
  end

  // R9
  no_unenabled_det_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (det_q & ~$past(sw_hit) & ~$past(rise_en | fall_en)) == '0);
endmodule

// File: rtl/eic_pend.sv
module eic_pend #(
  parameter int NUM_LINES = 24
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] det,
  input  logic [NUM_LINES-1:0] irq_msk,
  input  logic [NUM_LINES-1:0] clr,
  output logic [NUM_LINES-1:0] pend_q
);
  logic [NUM_LINES-1:0] set_bits;

  function automatic logic [NUM_LINES-1:0] next_pend(
    input logic [NUM_LINES-1:0] cur, input logic [NUM_LINES-1:0] s,
    input logic [NUM_LINES-1:0] c);
    return (cur & ~c) | s;
  endfunction

  assign set_bits = det & irq_msk;

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= next_pend(pend_q, set_bits, clr);
  end

  // R6
  no_spurious_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q & ~$past(pend_q) & ~$past(set_bits)) == '0);
  // R7
  clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q & $past(clr & ~set_bits)) == '0);
  // R8
  set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (~pend_q & $past(set_bits)) == '0);
endmodule

// File: rtl/edge_irq_evt_ctrl.sv
module edge_irq_evt_ctrl
  import eic_pkg::*;
#(
  parameter int NUM_LINES = 24
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] line_in,
  input  logic                 wr_en,
  input  logic [2:0]           wr_sel,
  input  logic [NUM_LINES-1:0] wr_data,
  input  logic [2:0]           rd_sel,
  output logic [NUM_LINES-1:0] rd_data,
  output logic [NUM_LINES-1:0] irq_out,
  output logic [NUM_LINES-1:0] evt_out
);
  logic [NUM_LINES-1:0] rise_en, fall_en, irq_msk, evt_msk;
  logic [NUM_LINES-1:0] sw_hit, pend_clr, raw_hit, det_q, pend_q;

  eic_cfg_regs #(.NUM_LINES(NUM_LINES)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rise_en(rise_en), .fall_en(fall_en),
    .irq_msk(irq_msk), .evt_msk(evt_msk), .sw_hit(sw_hit),
    .pend_clr(pend_clr));

  eic_edge_det #(.NUM_LINES(NUM_LINES)) u_det (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .rise_en(rise_en),
    .fall_en(fall_en), .sw_hit(sw_hit), .raw_hit(raw_hit), .det_q(det_q));

  eic_pend #(.NUM_LINES(NUM_LINES)) u_pend (
    .clk(clk), .rst_n(rst_n), .det(det_q), .irq_msk(irq_msk),
    .clr(pend_clr), .pend_q(pend_q));

  assign irq_out = pend_q & irq_msk;
  assign evt_out = det_q & evt_msk;

  always_comb begin
    case (rd_sel)
      SEL_RISE: rd_data = rise_en;
      SEL_FALL: rd_data = fall_en;
      SEL_IMSK: rd_data = irq_msk;
      SEL_EMSK: rd_data = evt_msk;
      SEL_PEND: rd_data = pend_q;
      default:  rd_data = '0;
    endcase
  end

  // R5
  evt_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_out & ~$past(raw_hit)) == '0);
  // R6
  irq_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out & ~u_pend.pend_q) == '0);
endmodule

// File: tb/sim_edge_irq_evt_ctrl.sv
`timescale 1ns/1ps
module sim_edge_irq_evt_ctrl;
  localparam int N = 24;
  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [N-1:0] line_in = '0, wr_data = '0;
  logic [2:0] wr_sel = '0, rd_sel = '0;
  logic [N-1:0] rd_data, irq_out, evt_out;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  edge_irq_evt_ctrl #(.NUM_LINES(N)) u0 (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel),
    .rd_data(rd_data), .irq_out(irq_out), .evt_out(evt_out));

  task automatic chk(input string req, input logic [N-1:0] act,
                     input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [N-1:0] d);
    @(negedge clk); wr_en = 1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 0; wr_data = '0;
  endtask

  task automatic rd_chk(input string req, input logic [2:0] sel,
                        input logic [N-1:0] exp);
    rd_sel = sel; #0.1; chk(req, rd_data, exp);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    for (int s = 0; s < 8; s++) rd_chk("R1 reg reset", 3'(s), '0);
    chk("R1 irq reset", irq_out, '0);
    chk("R1 evt reset", evt_out, '0);

    // R3 R4 R5 R6 R7 sweep: every line, every config
    for (int l = 0; l < N; l++) begin
      for (int c = 0; c < 16; c++) begin
        logic [N-1:0] b, hr, hf;
        logic im, em;
        b = N'(1) << l;
        im = c[2]; em = c[3];
        wr(3'd0, c[0] ? b : '0);
        wr(3'd1, c[1] ? b : '0);
        wr(3'd2, im ? b : '0);
        wr(3'd3, em ? b : '0);
        wr(3'd4, '1);
        hr = c[0] ? b : '0;
        hf = c[1] ? b : '0;
        @(negedge clk); line_in = b;
        @(negedge clk);
        chk("R3 R5 evt after rise", evt_out, em ? hr : '0);
        @(negedge clk);
        chk("R5 evt one cycle", evt_out, '0);
        chk("R3 R6 irq after rise", irq_out, im ? hr : '0);
        rd_chk("R6 pend after rise", 3'd4, im ? hr : '0);
        wr(3'd4, b);
        chk("R7 irq cleared", irq_out, '0);
        line_in = '0;
        @(negedge clk);
        chk("R4 R5 evt after fall", evt_out, em ? hf : '0);
        @(negedge clk);
        chk("R4 R6 irq after fall", irq_out, im ? hf : '0);
      end
    end

    // R2 register map and ignored selects
    wr(3'd0, 24'h00_00A5); wr(3'd1, 24'h00_5A00); wr(3'd2, 24'hF0_0000);
    wr(3'd3, 24'h0F_0000); wr(3'd4, '1);
    wr(3'd6, '1); wr(3'd7, '1);
    rd_chk("R2 rise reg", 3'd0, 24'h00_00A5);
    rd_chk("R2 fall reg", 3'd1, 24'h00_5A00);
    rd_chk("R2 imsk reg", 3'd2, 24'hF0_0000);
    rd_chk("R2 emsk reg", 3'd3, 24'h0F_0000);
    rd_chk("R2 sel6 reads 0", 3'd6, '0);
    rd_chk("R2 sel7 reads 0", 3'd7, '0);
    chk("R2 no trigger from sel6/7", irq_out | evt_out, '0);

    // R9 software trigger with edge enables clear
    wr(3'd0, '0); wr(3'd1, '0); wr(3'd2, 24'h00_0028); wr(3'd3, 24'h00_0028);
    wr(3'd5, 24'h00_0028);
    chk("R9 evt from sw trigger", evt_out, 24'h00_0028);
    @(negedge clk);
    chk("R9 irq from sw trigger", irq_out, 24'h00_0028);
    rd_chk("R2 R9 swtrig reads 0", 3'd5, '0);
    // R7 partial clear: 0 bits untouched
    wr(3'd4, 24'h00_0008);
    rd_chk("R7 partial clear", 3'd4, 24'h00_0020);
    wr(3'd4, '1);

    // R8 clear meets fresh detection
    wr(3'd0, 24'h00_0002); wr(3'd1, 24'h00_0002); wr(3'd2, 24'h00_0002);
    @(negedge clk); line_in = 24'h00_0002;
    @(negedge clk); @(negedge clk);
    chk("R8 setup pending", irq_out, 24'h00_0002);
    line_in = '0;
    wr(3'd4, 24'h00_0002);
    chk("R8 set wins over clear", irq_out, 24'h00_0002);
    wr(3'd4, 24'h00_0002);
    chk("R8 later clear works", irq_out, '0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule